// File: doc/BRIEF.md
# Cluster Control Register Unit

This block holds the control and status registers for a processor cluster of four cores. Software reaches it over a plain 32-bit register bus that has separate write and read strobes, a byte address, and write and read data. A write takes effect at the clock edge where the write strobe is high. Read data is registered: it appears on `rdata_o` after the edge that samples the read strobe, and it holds until the next read.

Each core has a 64-bit reset vector base. Software writes it as two 32-bit halves, and the block exports the full value as a port. A one-source interrupt unit has status, mask, enable and disable words. A hardware error pulse raises the source, and a single level output signals it. There are also five general configuration words.

Power-down requests are set per core through a power control word. Each request drives a power status output directly. The block registers each core's idle (wait-for-interrupt) input and ANDs it with that core's request, so the power manager is told only about cores that are both asked to power down and idle.

Top module: `cluster_ctrl_regs`

## Requirements
- R1: After reset, each core's reset vector low word is 0xFFFF0000 and its high word is 0, so every 64-bit `rvbar_o` lane reads 0x00000000_FFFF0000.
- R2: For core i, the low word is at 0x40+8*i and the high word at 0x44+8*i. A write to either half updates bits [i*64 +: 64] of `rvbar_o` after that write's edge, and the value reads back.
- R3: Status bit 0 (offset 0x10) is set by a high `err_pulse_i` and cleared by writing 1 to bit 0. When both happen in the same cycle, the bit ends up set.
- R4: The mask word (offset 0x14) resets to 0x1. Bus writes to it are ignored.
- R5: Writing 1 to bit 0 of the enable word (0x18) clears mask bit 0. Writing 1 to bit 0 of the disable word (0x1C) sets it. Both words read as 0.
- R6: `irq_o` is high exactly when status bit 0 is set and mask bit 0 is clear. It reflects a status, enable or disable write from the cycle after that write.
- R7: A write to the power control word (0x90) loads bits 3:0 as the per-core power-down requests. `pwr_stat_o` equals these requests, and the power control word reads them back in bits 3:0.
- R8: `idle_o[i]` is the AND of request i and `wfi_i[i]`, where `wfi_i[i]` is registered once. A change on `wfi_i` therefore shows on `idle_o` one cycle later.
- R9: Reset clears the requests and the registered idle inputs. Offset 0x20 resets to 0xF0F and offset 0x60 to 0x000F000F. Offsets 0x00, 0x24 and 0x64 reset to 0 and are plain read/write words.
- R10: In the power status word (0x94), bits 3:0 read the current requests and bits 17:16 read 0. Writes to those bits are ignored, and every other bit is read/write storage.
- R11: An access whose address has bits 1:0 not both zero is ignored: it writes nothing and reads 0. A read of an unmapped aligned offset also returns 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wr_en_i | input | 1 | Register write strobe |
| rd_en_i | input | 1 | Register read strobe |
| addr_i | input | 8 | Byte address |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Registered read data |
| err_pulse_i | input | 1 | Hardware error event, sets status bit 0 |
| irq_o | output | 1 | Interrupt request level |
| wfi_i | input | 4 | Per-core idle (wait-for-interrupt) inputs |
| pwr_stat_o | output | 4 | Per-core power-down request status |
| idle_o | output | 4 | Per-core idle-and-requested outputs to the power manager |
| rvbar_o | output | 256 | Four 64-bit reset vector bases, core i at [i*64 +: 64] |

## Verification
An error pulse and a write-one-to-clear of status bit 0 can land on the same clock edge. The bench provokes this by raising `err_pulse_i` and driving a write of 1 to offset 0x10 in the same cycle. It then reads the status word and expects 1, because the set has priority.

A second overlap comes from an idle input that changes while software is rewriting the power request. Here the bench expects `idle_o` to follow the AND of the new request and the registered idle input.

// File: rtl/cluster_ctrl_pkg.sv
package cluster_ctrl_pkg;
  localparam logic [7:0] OFF_ERR     = 8'h00;
  localparam logic [7:0] OFF_ISR     = 8'h10;
  localparam logic [7:0] OFF_IMR     = 8'h14;
  localparam logic [7:0] OFF_IEN     = 8'h18;
  localparam logic [7:0] OFF_IDS     = 8'h1C;
  localparam logic [7:0] OFF_CFG0    = 8'h20;
  localparam logic [7:0] OFF_CFG1    = 8'h24;
  localparam logic [7:0] OFF_VEC     = 8'h40;
  localparam logic [7:0] OFF_COH     = 8'h60;
  localparam logic [7:0] OFF_SNP     = 8'h64;
  localparam logic [7:0] OFF_PWRCTL  = 8'h90;
  localparam logic [7:0] OFF_PWRSTAT = 8'h94;

  localparam logic [31:0] RST_VEC_LO  = 32'hFFFF_0000;
  localparam logic [31:0] RST_CFG0    = 32'h0000_0F0F;
  localparam logic [31:0] RST_COH     = 32'h000F_000F;
  localparam logic [31:0] PWRSTAT_RO  = 32'h0003_000F;
endpackage

// File: rtl/ccr_vector_bank.sv
module ccr_vector_bank #(
  parameter int NUM_CORES = 4,
  parameter int DW        = 32
) (
  input  logic                      clk_i,
  input  logic                      rst_ni,
  input  logic                      wr_i,
  input  logic [7:0]                addr_i,
  input  logic [DW-1:0]             wdata_i,
  output logic [NUM_CORES*2*DW-1:0] vec_o,
  output logic                      hit_o,
  output logic [DW-1:0]             rdata_o
);
  import cluster_ctrl_pkg::*;

  logic [NUM_CORES-1:0] hit_lo, hit_hi;
  logic [DW-1:0]        lo_q [NUM_CORES];
  logic [DW-1:0]        hi_q [NUM_CORES];

  for (genvar i = 0; i < NUM_CORES; i++) begin : g_core
    assign hit_lo[i] = (addr_i == OFF_VEC + 8'(8*i));
    assign hit_hi[i] = (addr_i == OFF_VEC + 8'(8*i + 4));

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        lo_q[i] <= RST_VEC_LO[DW-1:0];
        hi_q[i] <= '0;
      end else begin
        if (wr_i && hit_lo[i]) lo_q[i] <= wdata_i;
        if (wr_i && hit_hi[i]) hi_q[i] <= wdata_i;
      end
    end

    assign vec_o[i*2*DW +: 2*DW] = {hi_q[i], lo_q[i]};

    p_lo_write_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (wr_i && hit_lo[i]) |=> (vec_o[i*2*DW +: DW] == $past(wdata_i)));
    p_hi_write_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (wr_i && hit_hi[i]) |=> (vec_o[i*2*DW+DW +: DW] == $past(wdata_i)));
  end

  always_comb begin
    rdata_o = '0;
    for (int i = 0; i < NUM_CORES; i++) begin
      if (hit_lo[i]) rdata_o = lo_q[i];
      if (hit_hi[i]) rdata_o = hi_q[i];
    end
  end

  assign hit_o = |{hit_lo, hit_hi};
endmodule

// File: rtl/ccr_irq_unit.sv
module ccr_irq_unit (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic wr_isr_i,
  input  logic wr_ien_i,
  input  logic wr_ids_i,
  input  logic wbit_i,
  input  logic err_pulse_i,
  output logic status_o,
  output logic mask_o,
  output logic irq_o
);
  logic status_q, mask_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      status_q <= 1'b0;
    end else if (err_pulse_i) begin
      status_q <= 1'b1;            // set beats clear
    end else if (wr_isr_i && wbit_i) begin
      status_q <= 1'b0;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mask_q <= 1'b1;
    end else if (wr_ien_i && wbit_i) begin
      mask_q <= 1'b0;
    end else if (wr_ids_i && wbit_i) begin
      mask_q <= 1'b1;
    end
  end

  assign status_o = status_q;
  assign mask_o   = mask_q;
  assign irq_o    = status_q & ~mask_q;

  p_set_wins_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err_pulse_i |=> status_o);
  p_w1c_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_isr_i && wbit_i && !err_pulse_i) |=> !status_o);
  p_ien_clears_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_ien_i && wbit_i) |=> !mask_o);
  p_ids_quiet_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_ids_i && wbit_i) |=> !irq_o);
endmodule

// File: rtl/ccr_pwr_unit.sv
module ccr_pwr_unit #(
  parameter int NUM_CORES = 4
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 wr_ctl_i,
  input  logic [NUM_CORES-1:0] wreq_i,
  input  logic [NUM_CORES-1:0] wfi_i,
  output logic [NUM_CORES-1:0] req_o,
  output logic [NUM_CORES-1:0] idle_o
);
  logic [NUM_CORES-1:0] req_q, wfi_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      req_q <= '0;
      wfi_q <= '0;
    end else begin
      wfi_q <= wfi_i;
      if (wr_ctl_i) req_q <= wreq_i;
    end
  end

  assign req_o = req_q;

  for (genvar i = 0; i < NUM_CORES; i++) begin : g_core
    assign idle_o[i] = req_q[i] & wfi_q[i];

    p_idle_past_wfi_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
      idle_o[i] |-> $past(wfi_i[i]));
  end

  p_req_load_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_ctl_i |=> (req_o == $past(wreq_i)));
endmodule

// File: rtl/cluster_ctrl_regs.sv
module cluster_ctrl_regs #(
  parameter int NUM_CORES = 4,
  parameter int DW        = 32,
  parameter int AW        = 8
) (
  input  logic                      clk_i,
  input  logic                      rst_ni,
  input  logic                      wr_en_i,
  input  logic                      rd_en_i,
  input  logic [AW-1:0]             addr_i,
  input  logic [DW-1:0]             wdata_i,
  output logic [DW-1:0]             rdata_o,
  input  logic                      err_pulse_i,
  output logic                      irq_o,
  input  logic [NUM_CORES-1:0]      wfi_i,
  output logic [NUM_CORES-1:0]      pwr_stat_o,
  output logic [NUM_CORES-1:0]      idle_o,
  output logic [NUM_CORES*2*DW-1:0] rvbar_o
);
  import cluster_ctrl_pkg::*;

  logic          aligned, wr, rd;
  logic [7:0]    a8;
  logic [DW-1:0] err_q, cfg0_q, cfg1_q, coh_q, snp_q, pstat_q;
  logic [DW-1:0] vec_rd, rd_word;
  logic          vec_hit;
  logic          status, mask;
  logic [NUM_CORES-1:0] req;

  assign a8      = addr_i[7:0];
  assign aligned = (addr_i[1:0] == 2'b00);
  assign wr      = wr_en_i & aligned;
  assign rd      = rd_en_i & aligned;

  ccr_vector_bank #(.NUM_CORES(NUM_CORES), .DW(DW)) u_vec (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .wr_i    (wr),
    .addr_i  (a8),
    .wdata_i (wdata_i),
    .vec_o   (rvbar_o),
    .hit_o   (vec_hit),
    .rdata_o (vec_rd)
  );

  ccr_irq_unit u_irq (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .wr_isr_i    (wr && a8 == OFF_ISR),
    .wr_ien_i    (wr && a8 == OFF_IEN),
    .wr_ids_i    (wr && a8 == OFF_IDS),
    .wbit_i      (wdata_i[0]),
    .err_pulse_i (err_pulse_i),
    .status_o    (status),
    .mask_o      (mask),
    .irq_o       (irq_o)
  );

  ccr_pwr_unit #(.NUM_CORES(NUM_CORES)) u_pwr (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .wr_ctl_i (wr && a8 == OFF_PWRCTL),
    .wreq_i   (wdata_i[NUM_CORES-1:0]),
    .wfi_i    (wfi_i),
    .req_o    (req),
    .idle_o   (idle_o)
  );

  assign pwr_stat_o = req;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      err_q   <= '0;
      cfg0_q  <= RST_CFG0[DW-1:0];
      cfg1_q  <= '0;
      coh_q   <= RST_COH[DW-1:0];
      snp_q   <= '0;
      pstat_q <= '0;
    end else if (wr) begin
      case (a8)
        OFF_ERR:     err_q   <= wdata_i;
        OFF_CFG0:    cfg0_q  <= wdata_i;
        OFF_CFG1:    cfg1_q  <= wdata_i;
        OFF_COH:     coh_q   <= wdata_i;
        OFF_SNP:     snp_q   <= wdata_i;
        OFF_PWRSTAT: pstat_q <= wdata_i & ~PWRSTAT_RO[DW-1:0];
        default: ;
      endcase
    end
  end

  always_comb begin
    rd_word = '0;
    case (a8)
      OFF_ERR:     rd_word = err_q;
      OFF_ISR:     rd_word[0] = status;
      OFF_IMR:     rd_word[0] = mask;
      OFF_CFG0:    rd_word = cfg0_q;
      OFF_CFG1:    rd_word = cfg1_q;
      OFF_COH:     rd_word = coh_q;
      OFF_SNP:     rd_word = snp_q;
      OFF_PWRCTL:  rd_word[NUM_CORES-1:0] = req;
      OFF_PWRSTAT: begin
        rd_word = pstat_q & ~PWRSTAT_RO[DW-1:0];
        rd_word[NUM_CORES-1:0] = req;
      end
      default:     if (vec_hit) rd_word = vec_rd;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     rdata_o <= '0;
    else if (rd_en_i) rdata_o <= rd ? rd_word : '0;
  end

  p_misaligned_read_zero_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_en_i && addr_i[1:0] != 2'b00) |=> (rdata_o == '0));
  p_pwrstat_ro_zero_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_en_i && addr_i == AW'(OFF_PWRSTAT)) |=> (rdata_o[17:16] == 2'b00));
  p_stat_tracks_write_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && addr_i == AW'(OFF_PWRCTL)) |=> (pwr_stat_o == $past(wdata_i[NUM_CORES-1:0])));
endmodule

// File: tb/cluster_ctrl_regs_test.sv
`timescale 1ns/1ps
module cluster_ctrl_regs_test;
  logic         clk = 0, rst_ni = 0;
  logic         wr_en = 0, rd_en = 0, err_pulse = 0;
  logic [7:0]   addr = 0;
  logic [31:0]  wdata = 0;
  logic [31:0]  rdata;
  logic         irq;
  logic [3:0]   wfi = 0, pwr_stat, idle;
  logic [255:0] rvbar;
  int n_run = 0, n_fail = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  cluster_ctrl_regs uut (
    .clk_i(clk), .rst_ni(rst_ni), .wr_en_i(wr_en), .rd_en_i(rd_en),
    .addr_i(addr), .wdata_i(wdata), .rdata_o(rdata), .err_pulse_i(err_pulse),
    .irq_o(irq), .wfi_i(wfi), .pwr_stat_o(pwr_stat), .idle_o(idle),
    .rvbar_o(rvbar)
  );

  task automatic chk(string tag, logic [63:0] act, logic [63:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
    end
  endtask

  task automatic wr(logic [7:0] a, logic [31:0] d);
    @(negedge clk); wr_en = 1; addr = a; wdata = d;
    @(negedge clk); wr_en = 0;
  endtask

  task automatic rd(logic [7:0] a, output logic [31:0] d);
    @(negedge clk); rd_en = 1; addr = a;
    @(negedge clk); rd_en = 0; d = rdata;
  endtask

  task automatic t_reset();
    logic [31:0] d;
    for (int i = 0; i < 4; i++) chk("R1 vector reset", rvbar[i*64 +: 64], 64'h0000_0000_FFFF_0000);
    rd(8'h20, d); chk("R9 cfg0 reset", d, 32'hF0F);
    rd(8'h60, d); chk("R9 coherency reset", d, 32'h000F_000F);
    rd(8'h24, d); chk("R9 cfg1 reset", d, 0);
    rd(8'h14, d); chk("R4 mask reset", d, 1);
    chk("R9 req reset", pwr_stat, 0);
    chk("R6 irq reset", irq, 0);
  endtask

  task automatic t_vectors();
    logic [31:0] d;
    wr(8'h50, 32'h1234_5678);
    chk("R2 core2 low", rvbar[128 +: 64], 64'h0000_0000_1234_5678);
    wr(8'h5C, 32'hCAFE_0001);
    chk("R2 core3 high", rvbar[192 +: 64], 64'hCAFE_0001_FFFF_0000);
    rd(8'h50, d); chk("R2 readback", d, 32'h1234_5678);
    chk("R2 core0 untouched", rvbar[0 +: 64], 64'h0000_0000_FFFF_0000);
  endtask

  task automatic t_irq_flow();
    logic [31:0] d;
    @(negedge clk); err_pulse = 1; @(negedge clk); err_pulse = 0;
    rd(8'h10, d); chk("R3 status set", d, 1);
    chk("R6 masked irq low", irq, 0);
    wr(8'h14, 0); rd(8'h14, d); chk("R4 mask write ignored", d, 1);
    wr(8'h18, 1); chk("R6 irq after enable", irq, 1);
    rd(8'h14, d); chk("R5 enable clears mask", d, 0);
    rd(8'h18, d); chk("R5 enable reads 0", d, 0);
    wr(8'h10, 1); chk("R3 w1c clears", irq, 0);
    @(negedge clk); err_pulse = 1; @(negedge clk); err_pulse = 0;
    chk("R6 irq reasserts", irq, 1);
    wr(8'h1C, 1); chk("R6 irq after disable", irq, 0);
    rd(8'h14, d); chk("R5 disable sets mask", d, 1);
    rd(8'h1C, d); chk("R5 disable reads 0", d, 0);
  endtask

  task automatic t_set_wins();
    logic [31:0] d;
    wr(8'h10, 1);
    @(negedge clk); err_pulse = 1; wr_en = 1; addr = 8'h10; wdata = 1;
    @(negedge clk); err_pulse = 0; wr_en = 0;
    rd(8'h10, d); chk("R3 set wins over clear", d, 1);
    wr(8'h10, 1); rd(8'h10, d); chk("R3 cleared after", d, 0);
  endtask

  task automatic t_power();
    logic [31:0] d;
    wr(8'h90, 32'hFFFF_FFF5);
    chk("R7 status follows", pwr_stat, 4'h5);
    rd(8'h90, d); chk("R7 readback", d, 32'h5);
    @(negedge clk); wfi = 4'hF;
    chk("R8 idle waits a cycle", idle, 0);
    @(negedge clk); chk("R8 idle AND", idle, 4'h5);
    @(negedge clk); wr_en = 1; addr = 8'h90; wdata = 32'h2; wfi = 4'hA;
    @(negedge clk); wr_en = 0;
    chk("R8 overlap update", idle, 4'h2);
    wfi = 0; @(negedge clk); chk("R8 idle drops", idle, 0);
    wr(8'h90, 32'h5);
  endtask

  task automatic t_pwrstat();
    logic [31:0] d;
    wr(8'h94, 32'hFFFF_FFFF);
    rd(8'h94, d); chk("R10 ro bits", d, 32'hFFFC_FFF5);
    wr(8'h94, 0);
    rd(8'h94, d); chk("R10 rw bits cleared", d, 32'h5);
  endtask

  task automatic t_access();
    logic [31:0] d;
    wr(8'h25, 32'hDEAD_BEEF);
    rd(8'h24, d); chk("R11 misaligned write ignored", d, 0);
    wr(8'h24, 32'h0000_ABCD);
    rd(8'h26, d); chk("R11 misaligned read 0", d, 0);
    rd(8'h30, d); chk("R11 unmapped read 0", d, 0);
    rd(8'h24, d); chk("R9 cfg1 rw", d, 32'hABCD);
    wr(8'h00, 32'h8000_0001); rd(8'h00, d); chk("R9 err ctrl rw", d, 32'h8000_0001);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_ni = 1;
    @(negedge clk);
    t_reset();
    t_vectors();
    t_irq_flow();
    t_set_wins();
    t_power();
    t_pwrstat();
    t_access();
    done = 1;
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_run++; n_fail++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end
endmodule